// File: doc/BRIEF.md
# Bit-plane regrouping cluster accumulator

This block sits behind the distance chain of a bit-serial clustering engine. Sample data arrives as a stream of bit planes. Each 16-bit word carries one bit of each of the 16 features in a feature group. For one group the words run from the most significant bit downward, and after the last kept bit the stream moves on to the next group. The block rebuilds the 32-bit value of each feature from this stream and adds it into a per-cluster, per-coordinate running sum. It also counts how many samples each cluster has received.

The precision (how many planes per group) and the number of feature groups per sample are run-time settings. The cluster index for a sample comes from the distance chain on a separate strobe. It may come before or during the sample's stream. Rebuilt groups wait in a small queue until the cluster index is known. Software pulses `clear` at the start of each iteration. Once `done` is high, it reads the sums and counts through a synchronous read port. Aggregation across several such blocks and the division into new centres are handled outside.

Top module: `bitplane_cluster_accum`

## Requirements
- R1: After reset, `done` is high within two clock edges, and every read returns a sum of 0 and a count of 0.
- R2: Word bit l of a plane word belongs to feature (group·16 + l). The first word of a group is bit 31 of every feature. Each following word is the next lower bit. After `cfg_prec` words (1 to 32) the group is complete. Bits below the last received plane are zero in the rebuilt value.
- R3: Each rebuilt feature is added, at full precision, into the sum held for (assigned cluster, feature index). Clusters and coordinates never mix.
- R4: The count of the assigned cluster rises by exactly one per completed sample. All other counts stay unchanged.
- R5: The cluster index (`assign_clust` with `assign_valid`) may arrive with the first plane of the sample or with a later plane. The block holds completed groups until it arrives, up to the buffer depth. Indices for later samples queue in arrival order.
- R6: A `clear` pulse returns every sum and every count to zero.
- R7: A sample covers `cfg_groups`·16 features (1 to 64 groups, so up to 1024 features). Feature indices at or above that limit keep their previous sum (zero after clear).
- R8: `done` is low in the cycle after any plane or index input. Once all queued work has been written, `done` goes high. A read address applied before a clock edge gives its sum and count after that edge.
- R9: Samples of one group at precision 1 for the same cluster may arrive in consecutive cycles, and every one of them is summed.
- R10: Sums are 48 bits wide. Totals above 2^32 keep their upper bits. For example, four features of value 0xFFFFFFFF sum to 0x3FFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Start of iteration: zero all sums and counts and drop queued work |
| cfg_prec | input | 6 | Planes per feature group, 1 to 32 |
| cfg_groups | input | 7 | Feature groups per sample, 1 to 64 |
| plane_valid | input | 1 | `plane_bits` carries a plane word this cycle |
| plane_bits | input | 16 | One bit plane of the 16 features of the current group |
| assign_valid | input | 1 | Cluster index for the next unassigned sample is present |
| assign_clust | input | 3 | Cluster index, 0 to 7 |
| rd_clust | input | 3 | Read address: cluster |
| rd_feat | input | 10 | Read address: feature index |
| rd_sum | output | 48 | Sum at the read address, one edge after the address |
| rd_count | output | 17 | Sample count of `rd_clust`, one edge after the address |
| done | output | 1 | All received work has been accumulated |

## Verification
The checker assumes the following about the inputs:
- The producer never overruns the group queue or the index queue.
- `cfg_prec` and `cfg_groups` change only while the block is idle.
- `clear` and reads are issued only while `done` is high.

The stimulus stays inside these limits:
- It changes settings and clears only after polling `done`.
- It sends each sample's index either with the first plane or at most one group late.
- It keeps precision-1 back-to-back traffic to one group per sample, so the queue drains as fast as it fills.

// File: rtl/bpacc_pkg.sv
package bpacc_pkg;

   localparam int unsigned BP_LANES     = 16;
   localparam int unsigned BP_FEAT_W    = 32;
   localparam int unsigned BP_MAX_CLUST = 8;
   localparam int unsigned BP_MAX_DIM   = 1024;
   localparam int unsigned BP_SAMP_LOG2 = 16;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bpacc_fifo.sv
module bpacc_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [W-1:0]  slot_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   fill_q;
   logic          do_push, do_pop;

   assign empty   = (fill_q == '0);
   assign full    = (fill_q == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = slot_q[rp_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
      end else if (clear) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + AW'(1);
         if (do_pop)  rp_q <= rp_q + AW'(1);
         if (do_push && !do_pop)      fill_q <= fill_q + (AW+1)'(1);
         else if (do_pop && !do_push) fill_q <= fill_q - (AW+1)'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slot_q[wp_q] <= din;
   end

endmodule

// File: rtl/bpacc_regroup.sv
module bpacc_regroup #(
   parameter int unsigned LANES  = 16,
   parameter int unsigned FEAT_W = 32,
   parameter int unsigned PREC_W = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic [PREC_W-1:0]            cfg_prec,
   input  logic                         plane_valid,
   input  logic [LANES-1:0]             plane_bits,
   output logic                         grp_valid,
   output logic [LANES-1:0][FEAT_W-1:0] grp_data,
   output logic                         busy
);
   localparam logic [PREC_W-1:0] TOP_BIT = PREC_W'(FEAT_W - 1);

   logic [PREC_W-1:0]            pcnt_q;
   logic [PREC_W-1:0]            shamt;
   logic                         first_plane, last_plane;
   logic [LANES-1:0][FEAT_W-1:0] lane_q, lane_nxt;

   assign first_plane = (pcnt_q == '0);
   assign last_plane  = (pcnt_q >= cfg_prec - PREC_W'(1));
   assign shamt       = TOP_BIT - pcnt_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_nxt[l] = (first_plane ? '0 : lane_q[l])
                         | (FEAT_W'(plane_bits[l]) << shamt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         lane_q <= '0;
      end else if (clear) begin
         pcnt_q <= '0;
      end else if (plane_valid) begin
         lane_q <= lane_nxt;
         pcnt_q <= last_plane ? '0 : pcnt_q + PREC_W'(1);
      end
   end

   assign grp_valid = plane_valid && last_plane && !clear;
   assign grp_data  = lane_nxt;
   assign busy      = !first_plane;

endmodule

// File: rtl/bpacc_sum_store.sv
module bpacc_sum_store #(
   parameter int unsigned LANES     = 16,
   parameter int unsigned FEAT_W    = 32,
   parameter int unsigned SUM_W     = 48,
   parameter int unsigned CNT_W     = 17,
   parameter int unsigned MAX_CLUST = 8,
   parameter int unsigned MAX_GRP   = 64,
   parameter int unsigned GCFG_W    = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clear,
   input  logic [GCFG_W-1:0]                cfg_groups,
   input  logic                             gf_empty,
   input  logic [LANES-1:0][FEAT_W-1:0]     gf_data,
   output logic                             gf_pop,
   input  logic                             af_empty,
   input  logic [$clog2(MAX_CLUST)-1:0]     af_clust,
   output logic                             af_pop,
   input  logic [$clog2(MAX_CLUST)-1:0]     rd_clust,
   input  logic [$clog2(MAX_GRP)-1:0]       rd_grp,
   input  logic [$clog2(LANES)-1:0]         rd_lane,
   output logic [SUM_W-1:0]                 rd_sum,
   output logic [CNT_W-1:0]                 rd_count,
   output logic                             busy
);
   localparam int unsigned CL_W  = $clog2(MAX_CLUST);
   localparam int unsigned GRP_W = $clog2(MAX_GRP);
   localparam int unsigned AD_W  = CL_W + GRP_W;
   localparam int unsigned NENT  = MAX_CLUST * MAX_GRP;

   typedef logic [LANES-1:0][SUM_W-1:0] row_t;

   row_t                          mem [NENT];
   logic [NENT-1:0]               vld_q;
   logic [CNT_W-1:0]              cnt_q [MAX_CLUST];

   logic                          fire, last_grp;
   logic [GRP_W-1:0]              grp_q;
   logic [AD_W-1:0]               issue_addr, rd_addr;

   logic                          s1_v, s1_last;
   logic [AD_W-1:0]               s1_addr;
   logic [LANES-1:0][FEAT_W-1:0]  s1_data;
   row_t                          rmw_q, base, sum_nxt;
   logic                          vq;

   logic                          wb_v;
   logic [AD_W-1:0]               wb_addr;
   row_t                          wb_sum;

   assign fire       = !gf_empty && !af_empty;
   assign last_grp   = (grp_q == GRP_W'(cfg_groups - GCFG_W'(1)));
   assign gf_pop     = fire;
   assign af_pop     = fire && last_grp;
   assign issue_addr = {af_clust, grp_q};
   assign rd_addr    = {rd_clust, rd_grp};
   assign busy       = s1_v;

   // newest write to the same row wins over the stale synchronous read
   assign base = (wb_v && wb_addr == s1_addr) ? wb_sum : (vq ? rmw_q : '0);

   for (genvar l = 0; l < LANES; l++) begin : g_add
      assign sum_nxt[l] = base[l] + SUM_W'(s1_data[l]);
   end

   always_ff @(posedge clk) begin
      rmw_q <= mem[issue_addr];
      if (s1_v) mem[s1_addr] <= sum_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v     <= 1'b0;
         s1_last  <= 1'b0;
         s1_addr  <= '0;
         s1_data  <= '0;
         vq       <= 1'b0;
         grp_q    <= '0;
         wb_v     <= 1'b0;
         wb_addr  <= '0;
         wb_sum   <= '0;
         vld_q    <= '0;
         rd_sum   <= '0;
         rd_count <= '0;
         for (int c = 0; c < int'(MAX_CLUST); c++) cnt_q[c] <= '0;
      end else begin
         rd_sum   <= vld_q[rd_addr] ? mem[rd_addr][rd_lane] : '0;
         rd_count <= cnt_q[rd_clust];
         if (clear) begin
            s1_v  <= 1'b0;
            wb_v  <= 1'b0;
            grp_q <= '0;
            vld_q <= '0;
            for (int c = 0; c < int'(MAX_CLUST); c++) cnt_q[c] <= '0;
         end else begin
            s1_v    <= fire;
            s1_last <= last_grp;
            s1_addr <= issue_addr;
            s1_data <= gf_data;
            vq      <= vld_q[issue_addr];
            if (fire) grp_q <= last_grp ? '0 : grp_q + GRP_W'(1);
            wb_v    <= s1_v;
            wb_addr <= s1_addr;
            wb_sum  <= sum_nxt;
            if (s1_v) begin
               vld_q[s1_addr] <= 1'b1;
               if (s1_last)
                  cnt_q[s1_addr[AD_W-1 -: CL_W]] <= cnt_q[s1_addr[AD_W-1 -: CL_W]] + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/bitplane_cluster_accum.sv
module bitplane_cluster_accum #(
   parameter int unsigned LANES      = bpacc_pkg::BP_LANES,
   parameter int unsigned FEAT_W     = bpacc_pkg::BP_FEAT_W,
   parameter int unsigned MAX_CLUST  = bpacc_pkg::BP_MAX_CLUST,
   parameter int unsigned MAX_DIM    = bpacc_pkg::BP_MAX_DIM,
   parameter int unsigned SAMP_LOG2  = bpacc_pkg::BP_SAMP_LOG2,
   parameter int unsigned GBUF_DEPTH = 4,
   parameter int unsigned ABUF_DEPTH = 4,
   localparam int unsigned MAX_GRP   = MAX_DIM / LANES,
   localparam int unsigned CL_W      = $clog2(MAX_CLUST),
   localparam int unsigned FI_W      = $clog2(MAX_DIM),
   localparam int unsigned LANE_W    = $clog2(LANES),
   localparam int unsigned PREC_W    = $clog2(FEAT_W) + 1,
   localparam int unsigned GCFG_W    = $clog2(MAX_GRP) + 1,
   localparam int unsigned SUM_W     = FEAT_W + SAMP_LOG2,
   localparam int unsigned CNT_W     = SAMP_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [PREC_W-1:0] cfg_prec,
   input  logic [GCFG_W-1:0] cfg_groups,
   input  logic              plane_valid,
   input  logic [LANES-1:0]  plane_bits,
   input  logic              assign_valid,
   input  logic [CL_W-1:0]   assign_clust,
   input  logic [CL_W-1:0]   rd_clust,
   input  logic [FI_W-1:0]   rd_feat,
   output logic [SUM_W-1:0]  rd_sum,
   output logic [CNT_W-1:0]  rd_count,
   output logic              done
);
   if (!bpacc_pkg::is_pow2(LANES)) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end
   if (!bpacc_pkg::is_pow2(MAX_CLUST) || MAX_CLUST < 2) begin : g_bad_clust
      $error("MAX_CLUST must be a power of two, at least 2");
   end
   if ((MAX_DIM % LANES) != 0 || !bpacc_pkg::is_pow2(MAX_GRP) || MAX_GRP < 2) begin : g_bad_dim
      $error("MAX_DIM must be a power-of-two multiple of LANES");
   end
   if (!bpacc_pkg::is_pow2(GBUF_DEPTH) || GBUF_DEPTH < 2 ||
       !bpacc_pkg::is_pow2(ABUF_DEPTH) || ABUF_DEPTH < 2) begin : g_bad_buf
      $error("buffer depths must be powers of two, at least 2");
   end

   localparam int unsigned GW = LANES * FEAT_W;

   logic          gf_push, gf_pop, gf_empty, gf_full;
   logic [GW-1:0] grp_flat, gf_dout;
   logic          af_push, af_pop, af_empty, af_full;
   logic [CL_W-1:0] af_dout;
   logic          asm_busy, st_busy, idle;

   bpacc_regroup #(.LANES(LANES), .FEAT_W(FEAT_W), .PREC_W(PREC_W)) u_regroup (
      .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_prec(cfg_prec),
      .plane_valid(plane_valid), .plane_bits(plane_bits),
      .grp_valid(gf_push), .grp_data(grp_flat), .busy(asm_busy)
   );

   bpacc_fifo #(.W(GW), .DEPTH(GBUF_DEPTH)) u_gbuf (
      .clk(clk), .rst_n(rst_n), .clear(clear), .push(gf_push), .din(grp_flat),
      .pop(gf_pop), .dout(gf_dout), .empty(gf_empty), .full(gf_full)
   );

   assign af_push = assign_valid && !clear;

   bpacc_fifo #(.W(CL_W), .DEPTH(ABUF_DEPTH)) u_abuf (
      .clk(clk), .rst_n(rst_n), .clear(clear), .push(af_push), .din(assign_clust),
      .pop(af_pop), .dout(af_dout), .empty(af_empty), .full(af_full)
   );

   bpacc_sum_store #(
      .LANES(LANES), .FEAT_W(FEAT_W), .SUM_W(SUM_W), .CNT_W(CNT_W),
      .MAX_CLUST(MAX_CLUST), .MAX_GRP(MAX_GRP), .GCFG_W(GCFG_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_groups(cfg_groups),
      .gf_empty(gf_empty), .gf_data(gf_dout), .gf_pop(gf_pop),
      .af_empty(af_empty), .af_clust(af_dout), .af_pop(af_pop),
      .rd_clust(rd_clust), .rd_grp(rd_feat[FI_W-1:LANE_W]), .rd_lane(rd_feat[LANE_W-1:0]),
      .rd_sum(rd_sum), .rd_count(rd_count), .busy(st_busy)
   );

   assign idle = !asm_busy && gf_empty && af_empty && !st_busy
              && !plane_valid && !assign_valid && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= idle;
   end

endmodule

// File: rtl/bpacc_chk.sv
module bpacc_chk #(
   parameter int unsigned PREC_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear,
   input logic [PREC_W-1:0] cfg_prec,
   input logic              plane_valid,
   input logic              gf_push,
   input logic              gf_full,
   input logic              gf_empty,
   input logic              af_push,
   input logic              af_full,
   input logic              af_empty,
   input logic              st_busy,
   input logic              done
);
   // R2
   prec1_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plane_valid && !clear && cfg_prec == PREC_W'(1)) |-> gf_push);

   // R5
   gbuf_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gf_push && gf_full));

   // R5
   abuf_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(af_push && af_full));

   // R6
   clear_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (gf_empty && af_empty && !st_busy));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!st_busy && gf_empty && af_empty));
endmodule

bind bitplane_cluster_accum bpacc_chk #(.PREC_W(PREC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_prec(cfg_prec),
   .plane_valid(plane_valid), .gf_push(gf_push), .gf_full(gf_full),
   .gf_empty(gf_empty), .af_push(af_push), .af_full(af_full),
   .af_empty(af_empty), .st_busy(st_busy), .done(done)
);

// File: tb/tb_bitplane_cluster_accum.sv
module tb_bitplane_cluster_accum;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic [5:0]  cfg_prec = 6'd8;
   logic [6:0]  cfg_groups = 7'd2;
   logic        plane_valid = 1'b0;
   logic [15:0] plane_bits = '0;
   logic        assign_valid = 1'b0;
   logic [2:0]  assign_clust = '0;
   logic [2:0]  rd_clust = '0;
   logic [9:0]  rd_feat = '0;
   logic [47:0] rd_sum;
   logic [16:0] rd_count;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int log_c [64];
   int log_s [64];
   int log_p [64];
   int log_g [64];
   int nlog = 0;

   always #5 clk = ~clk;

   bitplane_cluster_accum dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_prec(cfg_prec),
      .cfg_groups(cfg_groups), .plane_valid(plane_valid), .plane_bits(plane_bits),
      .assign_valid(assign_valid), .assign_clust(assign_clust),
      .rd_clust(rd_clust), .rd_feat(rd_feat), .rd_sum(rd_sum),
      .rd_count(rd_count), .done(done)
   );

   // columns: cluster(4) precision(8) seed(8) late group(4)
   localparam logic [23:0] VEC [8] = '{
      24'h0_08_05_0, 24'h3_01_0B_1, 24'h7_20_11_0, 24'h3_05_17_0,
      24'h1_10_1D_1, 24'h0_03_1F_0, 24'h6_20_25_1, 24'h7_02_29_0
   };

   function automatic logic [31:0] featv(input int s, input int f);
      logic [31:0] x;
      if (s == 0) return 32'hFFFF_FFFF;
      x = (32'(s) * 32'h9E37_79B1) ^ (32'(f + 1) * 32'h7F4A_7C15);
      x = x ^ (x >> 13);
      x = x * 32'h5BD1_E995;
      return x ^ (x >> 7);
   endfunction

   function automatic logic [31:0] quant(input logic [31:0] v, input int p);
      return v & (32'hFFFF_FFFF << (32 - p));
   endfunction

   function automatic longint unsigned exp_sum(input int c, input int f);
      longint unsigned acc = 0;
      for (int n = 0; n < nlog; n++)
         if (log_c[n] == c && f < log_g[n] * 16)
            acc += longint'(quant(featv(log_s[n], f), log_p[n]));
      return acc;
   endfunction

   function automatic longint unsigned exp_cnt(input int c);
      longint unsigned k = 0;
      for (int n = 0; n < nlog; n++) if (log_c[n] == c) k++;
      return k;
   endfunction

   task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_sample(input int c, input int s, input int late);
      int p = int'(cfg_prec);
      int g = int'(cfg_groups);
      log_c[nlog] = c; log_s[nlog] = s; log_p[nlog] = p; log_g[nlog] = g;
      nlog++;
      for (int gi = 0; gi < g; gi++) begin
         for (int b = 0; b < p; b++) begin
            plane_valid = 1'b1;
            for (int l = 0; l < 16; l++) begin
               logic [31:0] v;
               v = featv(s, gi * 16 + l);
               plane_bits[l] = v[31 - b];
            end
            assign_valid = (gi == late) && (b == 0);
            assign_clust = 3'(c);
            @(negedge clk);
         end
      end
      plane_valid  = 1'b0;
      assign_valid = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000; i++) begin
         if (done) break;
         @(negedge clk);
      end
   endtask

   task automatic rd(input int c, input int f, output longint unsigned s, output longint unsigned n);
      rd_clust = 3'(c);
      rd_feat  = 10'(f);
      @(negedge clk);
      s = rd_sum;
      n = rd_count;
   endtask

   task automatic do_clear();
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      nlog = 0;
      @(negedge clk);
   endtask

   initial begin
      longint unsigned s, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);

      // R1: reset state
      chk("R1 done after reset", longint'(done), 1);
      rd(0, 0, s, n);
      chk("R1 count c0", n, 0);
      chk("R1 sum c0 f0", s, 0);
      rd(7, 1023, s, n);
      chk("R1 count c7", n, 0);
      chk("R1 sum c7 f1023", s, 0);

      // table walk: mixed precisions, clusters and late indices (R2 R3 R5)
      cfg_groups = 7'd2;
      for (int v = 0; v < 8; v++) begin
         cfg_prec = VEC[v][17:12];
         send_sample(int'(VEC[v][23:20]), int'(VEC[v][11:4]), int'(VEC[v][3:0]));
         if (v == 0) chk("R8 done low after input", longint'(done), 0);
         wait_done();
      end
      chk("R8 done high when drained", longint'(done), 1);
      for (int c = 0; c < 8; c++) begin
         rd(c, 0, s, n);
         chk("R4 count per cluster", n, exp_cnt(c));
      end
      foreach (VEC[v]) begin
         int c = int'(VEC[v][23:20]);
         rd(c, 7, s, n);  chk("R2 R3 sum f7", s, exp_sum(c, 7));
         rd(c, 16, s, n); chk("R3 R5 sum f16", s, exp_sum(c, 16));
         rd(c, 31, s, n); chk("R2 R3 sum f31", s, exp_sum(c, 31));
      end
      rd(0, 32, s, n);
      chk("R7 padding above groups", s, 0);

      // R6: clear
      do_clear();
      wait_done();
      rd(3, 7, s, n);
      chk("R6 sum cleared", s, 0);
      chk("R6 count cleared", n, 0);
      rd(7, 31, s, n);
      chk("R6 sum c7 cleared", s, 0);

      // R9: back-to-back single-group precision-1 samples, same cluster
      cfg_prec = 6'd1;
      cfg_groups = 7'd1;
      send_sample(2, 50, 0);
      send_sample(2, 51, 0);
      send_sample(2, 52, 0);
      wait_done();
      rd(2, 0, s, n);
      chk("R9 count back-to-back", n, 3);
      chk("R9 sum lane0", s, exp_sum(2, 0));
      rd(2, 15, s, n);
      chk("R9 sum lane15", s, exp_sum(2, 15));

      // R10: wide sums
      cfg_prec = 6'd32;
      for (int k = 0; k < 4; k++) send_sample(5, 0, 0);
      wait_done();
      rd(5, 0, s, n);
      chk("R10 sum above 2^32", s, 64'h3_FFFF_FFFC);
      chk("R4 count c5", n, 4);
      rd(5, 9, s, n);
      chk("R10 sum lane9", s, 64'h3_FFFF_FFFC);

      // R7: full 1024-feature sample
      do_clear();
      cfg_prec = 6'd1;
      cfg_groups = 7'd64;
      send_sample(7, 9, 0);
      wait_done();
      rd(7, 1023, s, n);
      chk("R7 last feature", s, exp_sum(7, 1023));
      chk("R7 count c7", n, 1);
      rd(7, 600, s, n);
      chk("R7 mid feature", s, exp_sum(7, 600));
      rd(6, 1023, s, n);
      chk("R3 other cluster untouched", s, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule